// File: doc/BRIEF.md
# Clock Enable and Reset Sequencer for an 8-bit Controller Core

This block sits beside a small 8-bit controller core and decides which parts of the chip receive clock enables. Software selects one of two low-power states by writing a two-bit request into a control register port. In the light sleep state (idle), the processor's clock enable drops. The enable for the peripheral side (timers, serial port, interrupt logic and RAM) stays active. In the deep sleep state (power-down), every enable drops and the request to keep the oscillator running is withdrawn.

Idle ends when any enabled interrupt request arrives. The processor resumes on the next machine-cycle boundary. A machine cycle is a fixed group of oscillator clocks, and the block marks its boundaries with a one-cycle strobe.

Power-down ends only through the external reset pin. A high level on the pin asks for the oscillator at once. The pin then has to be seen high on consecutive synchronized samples for two machine cycles before the core reset asserts. That reset also returns both low-power states to normal running.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: A write with `cfg_we` high and `cfg_wdata[0]` = 1 (`cfg_wdata[1]` = 0) from normal running enters idle at the next clock edge: `cpu_clk_en` = 0 while `periph_clk_en` = 1 and `osc_run` = 1.
- R2: A write with `cfg_wdata[1]` = 1 enters power-down at the next clock edge: `cpu_clk_en`, `periph_clk_en` and `osc_run` are all 0 while `rst_pin` is low.
- R3: In power-down, neither `irq_req` nor any register write changes the outputs; the state is held until a qualified core reset.
- R4: `core_reset` rises exactly SYNC_STAGES + 2*MC_CLKS (2 + 24 = 26) clock edges after `rst_pin` goes high and stays high. It falls SYNC_STAGES + 1 (3) edges after the pin goes low.
- R5: A single low synchronized sample of `rst_pin` clears the qualification count, so a fresh run of 24 high samples is needed after it.
- R6: While in power-down, `rst_pin` high drives `osc_run` high without waiting for a clock edge. The qualified reset that follows restores all enables one edge after `core_reset` rises.
- R7: In idle, an `irq_req` pulse (even a single cycle) brings `cpu_clk_en` back to 1 at the clock edge ending the next cycle in which `mc_boundary` is 1, and not before.
- R8: An asserted `core_reset` clears the idle and power-down states at the following edge, and both enables read 1.
- R9: A write with both bits set enters power-down, not idle.
- R10: All state is edge-triggered and static. Stopping the clock for any length of time changes no output, and the machine-cycle phase resumes where it stopped.
- R11: `mc_boundary` is high for one cycle in every MC_CLKS (12) clock cycles outside power-down, and stays 0 in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low |
| rst_pin | input | 1 | External reset pin, asynchronous, active-high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | bit0 idle request, bit1 power-down request |
| irq_req | input | 1 | OR of all enabled interrupt requests |
| cpu_clk_en | output | 1 | Clock enable for the processor |
| periph_clk_en | output | 1 | Clock enable for RAM, timers, serial port, interrupt logic |
| osc_run | output | 1 | Request to keep the oscillator running |
| core_reset | output | 1 | Qualified reset to the core |
| mc_boundary | output | 1 | One-cycle strobe on the last clock of each machine cycle |

## Verification
The hardest situation to reach is leaving power-down. The controller ignores every input except the reset pin there. The stimulus first enters power-down with a write that sets both request bits. It then tries interrupt pulses and further writes that must change nothing. Only then does it raise the pin and count the 26 edges to the qualified reset, followed by one more edge to the restored enables. A second hard case is an interrupt that arrives mid-cycle while idle. The bench pulses `irq_req` for a single cycle away from a boundary and then watches every cycle until the strobe.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pmode_e;

  localparam int CFG_W       = 2;
  localparam int CFG_IDLE_BIT = 0;
  localparam int CFG_PD_BIT   = 1;
endpackage

// File: rtl/pcc_rst_qual.sv
module pcc_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_d;

  // synchronizer chain, one flop per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  // count consecutive high samples, saturating; one low sample clears
  always_comb begin
    if (!sync_q[SYNC_STAGES-1])  cnt_d = '0;
    else if (cnt_q == CNT_FULL)  cnt_d = cnt_q;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/pcc_mcycle.sv
module pcc_mcycle #(
  parameter int MC_CLKS = 12
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_en,
  input  logic restart,
  output logic boundary_o
);
  localparam int PW = $clog2(MC_CLKS);
  localparam logic [PW-1:0] PH_LAST = PW'(MC_CLKS - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (restart)              phase_d = '0;
    else if (run_en) begin
      if (phase_q == PH_LAST) phase_d = '0;
      else                    phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign boundary_o = run_en && !restart && (phase_q == PH_LAST);
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   core_rst,
  input  logic   wr_en,
  input  logic   wr_idle,
  input  logic   wr_pd,
  input  logic   irq,
  input  logic   mc_bnd,
  output pmode_e mode_o
);
  pmode_e mode_q, mode_d;
  logic   pend_q, pend_d;

  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    if (core_rst) begin
      mode_d = PM_RUN;
      pend_d = 1'b0;
    end else begin
      case (mode_q)
        PM_RUN: begin
          pend_d = 1'b0;
          if (wr_en && wr_pd)        mode_d = PM_PDOWN;
          else if (wr_en && wr_idle) mode_d = PM_IDLE;
        end
        PM_IDLE: begin
          if (wr_en && wr_pd) begin
            mode_d = PM_PDOWN;
            pend_d = 1'b0;
          end else if (mc_bnd && (pend_q || irq)) begin
            mode_d = PM_RUN;
            pend_d = 1'b0;
          end else if (irq) begin
            pend_d = 1'b1;
          end
        end
        default: begin
          mode_d = PM_PDOWN;  // left only through core_rst
          pend_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= PM_RUN;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MC_CLKS     = 12,
  parameter int QUAL_MC     = 2
) (
  input  logic             clk_osc,
  input  logic             por_n,
  input  logic             rst_pin,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             irq_req,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_run,
  output logic             core_reset,
  output logic             mc_boundary
);
  localparam int QUAL_CYCLES = QUAL_MC * MC_CLKS;

  pmode_e mode;
  logic   in_pd;

  pcc_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CYCLES(QUAL_CYCLES)
  ) qual_i (
    .clk    (clk_osc),
    .por_n  (por_n),
    .pin_i  (rst_pin),
    .qual_o (core_reset)
  );

  pcc_mcycle #(
    .MC_CLKS(MC_CLKS)
  ) mc_i (
    .clk        (clk_osc),
    .por_n      (por_n),
    .run_en     (!in_pd),
    .restart    (core_reset),
    .boundary_o (mc_boundary)
  );

  pcc_mode_fsm fsm_i (
    .clk      (clk_osc),
    .por_n    (por_n),
    .core_rst (core_reset),
    .wr_en    (cfg_we),
    .wr_idle  (cfg_wdata[CFG_IDLE_BIT]),
    .wr_pd    (cfg_wdata[CFG_PD_BIT]),
    .irq      (irq_req),
    .mc_bnd   (mc_boundary),
    .mode_o   (mode)
  );

  assign in_pd         = (mode == PM_PDOWN);
  assign cpu_clk_en    = (mode == PM_RUN);
  assign periph_clk_en = !in_pd;
  // pin asks for the oscillator directly so reset can be qualified from power-down
  assign osc_run       = !in_pd || rst_pin;
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_osc,
  input logic       por_n,
  input logic       rst_pin,
  input logic       cfg_we,
  input logic [1:0] cfg_wdata,
  input logic       irq_req,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_run,
  input logic       core_reset,
  input logic       mc_boundary
);
  AST_IDLE_WRITE: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cpu_clk_en && cfg_we && cfg_wdata == 2'b01 && !core_reset) |=> (!cpu_clk_en && periph_clk_en)); // R1

  AST_PD_OSC_STOP: assert property (@(posedge clk_osc) disable iff (!por_n)
    (!osc_run) |-> (!periph_clk_en && !cpu_clk_en && !rst_pin)); // R2

  AST_PD_STICKY: assert property (@(posedge clk_osc) disable iff (!por_n)
    (!periph_clk_en && !core_reset) |=> !periph_clk_en); // R3

  AST_QUAL_PIN: assert property (@(posedge clk_osc) disable iff (!por_n)
    $rose(core_reset) |-> $past(rst_pin, SYNC_STAGES)); // R4

  AST_IDLE_EXIT_BND: assert property (@(posedge clk_osc) disable iff (!por_n)
    ($rose(cpu_clk_en) && $past(periph_clk_en) && !$past(core_reset)) |-> $past(mc_boundary)); // R7

  AST_RST_CLEARS: assert property (@(posedge clk_osc) disable iff (!por_n)
    core_reset |=> (cpu_clk_en && periph_clk_en)); // R8

  AST_PD_PRIO: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cfg_we && cfg_wdata[1] && periph_clk_en && !core_reset) |=> !periph_clk_en); // R9

  AST_BND_PULSE: assert property (@(posedge clk_osc) disable iff (!por_n)
    mc_boundary |=> !mc_boundary); // R11

  AST_BND_PD: assert property (@(posedge clk_osc) disable iff (!por_n)
    !periph_clk_en |-> !mc_boundary); // R11
endmodule

bind pwr_clk_ctrl pcc_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/pwr_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_tb_top;
  logic       clk_osc = 1'b0;
  logic       clk_go  = 1'b1;
  logic       por_n, rst_pin, cfg_we, irq_req;
  logic [1:0] cfg_wdata;
  logic       cpu_clk_en, periph_clk_en, osc_run, core_reset, mc_boundary;
  int         n_chk = 0;
  int         n_err = 0;

  pwr_clk_ctrl dut_i (
    .clk_osc(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .irq_req(irq_req), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_run(osc_run), .core_reset(core_reset),
    .mc_boundary(mc_boundary)
  );

  initial forever #2 clk_osc = clk_go ? ~clk_osc : clk_osc;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_osc);
  endtask

  task automatic wr(input logic [1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step(1);
    cfg_we = 1'b0; cfg_wdata = 2'b00;
  endtask

  task automatic wait_bnd;
    for (int i = 0; i < 40; i++) begin
      if (mc_boundary) break;
      step(1);
    end
  endtask

  task automatic t_reset;
    chk("R8 reset cpu_en", cpu_clk_en, 1'b1);
    chk("R8 reset periph_en", periph_clk_en, 1'b1);
    chk("R2 reset osc_run", osc_run, 1'b1);
    chk("R4 reset core_reset", core_reset, 1'b0);
  endtask

  task automatic t_mcycle;
    int gap = 0;
    wait_bnd();
    step(1);
    while (!mc_boundary && gap < 30) begin gap++; step(1); end
    chk("R11 boundary period 12", (gap + 1) == 12, 1'b1);
  endtask

  task automatic t_idle;
    wait_bnd();
    step(2);
    wr(2'b01);
    chk("R1 idle cpu_en", cpu_clk_en, 1'b0);
    chk("R1 idle periph_en", periph_clk_en, 1'b1);
    chk("R1 idle osc_run", osc_run, 1'b1);
    step(3);
    chk("R1 idle holds", cpu_clk_en, 1'b0);
    irq_req = 1'b1; step(1); irq_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (mc_boundary) break;
      chk("R7 no early exit", cpu_clk_en, 1'b0);
      step(1);
    end
    chk("R7 still idle in boundary cycle", cpu_clk_en, 1'b0);
    step(1);
    chk("R7 exit at boundary", cpu_clk_en, 1'b1);
  endtask

  task automatic t_qual;
    wr(2'b01);
    chk("R8 idle before reset", cpu_clk_en, 1'b0);
    rst_pin = 1'b1;
    step(25);
    chk("R4 not yet at 25", core_reset, 1'b0);
    step(1);
    chk("R4 asserted at 26", core_reset, 1'b1);
    step(1);
    chk("R8 idle cleared", cpu_clk_en, 1'b1);
    rst_pin = 1'b0;
    step(2);
    chk("R4 held 2 after release", core_reset, 1'b1);
    step(1);
    chk("R4 released at 3", core_reset, 1'b0);
  endtask

  task automatic t_glitch;
    rst_pin = 1'b1; step(20);
    rst_pin = 1'b0; step(1);
    rst_pin = 1'b1;
    step(25);
    chk("R5 count restarted", core_reset, 1'b0);
    step(1);
    chk("R5 asserted after full run", core_reset, 1'b1);
    rst_pin = 1'b0; step(4);
    chk("R5 released", core_reset, 1'b0);
  endtask

  task automatic t_pd;
    wr(2'b11);
    chk("R9 both bits give pd", periph_clk_en, 1'b0);
    chk("R2 pd cpu_en", cpu_clk_en, 1'b0);
    chk("R2 pd osc_run", osc_run, 1'b0);
    irq_req = 1'b1; step(1); irq_req = 1'b0;
    wr(2'b01);
    step(30);
    chk("R3 pd periph held", periph_clk_en, 1'b0);
    chk("R3 pd cpu held", cpu_clk_en, 1'b0);
    chk("R3 pd osc held", osc_run, 1'b0);
    chk("R11 no boundary in pd", mc_boundary, 1'b0);
    rst_pin = 1'b1;
    #1;
    chk("R6 pin wakes osc", osc_run, 1'b1);
    step(26);
    chk("R6 core_reset from pd", core_reset, 1'b1);
    chk("R6 still pd", periph_clk_en, 1'b0);
    step(1);
    chk("R6 periph restored", periph_clk_en, 1'b1);
    chk("R6 cpu restored", cpu_clk_en, 1'b1);
    rst_pin = 1'b0; step(4);
  endtask

  task automatic t_static;
    int more = 0;
    wait_bnd();
    step(5);
    clk_go = 1'b0;
    #400;
    chk("R10 cpu_en held", cpu_clk_en, 1'b1);
    chk("R10 boundary held", mc_boundary, 1'b0);
    clk_go = 1'b1;
    step(1);
    while (!mc_boundary && more < 30) begin more++; step(1); end
    chk("R10 phase resumed", (more + 1) == 7, 1'b1);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_pin = 1'b0; cfg_we = 1'b0; cfg_wdata = 2'b00; irq_req = 1'b0;
    step(3);
    t_reset();
    por_n = 1'b1;
    step(1);
    t_mcycle();
    t_idle();
    t_qual();
    t_glitch();
    t_pd();
    t_static();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule